// File: doc/BRIEF.md
# Queued Serial Transmitter with Run-Time Frame Format

This block turns bytes handed to it through a simple write port into asynchronous serial frames on a single output line. A producer pushes bytes into an internal first-in first-out buffer and does nothing else. The transmitter pulls each byte out as soon as the line is free and sends it without any further handshake. Frames follow one another with no idle gap for as long as bytes are queued.

Every frame has one low start bit. It carries 5 to 8 data bits, least significant first. An optional parity bit follows, then one or two high stop bits. All of these choices are live inputs. The baud rate is also a live input, given as a plain binary number of bits per second. A phase accumulator turns it into a tick at sixteen times the baud rate, and every serial bit lasts sixteen ticks. The format inputs are captured when a frame begins, so they can be changed while a frame is on the line.

Top module: `uart_fifo_tx`

## Requirements
- R1: After reset the line `txd` is high and `wr_full` is low. The line stays high whenever no frame is in progress.
- R2: A frame is a low start bit followed by the low-order data bits of the byte, least significant first. The number of data bits comes from `data_len`: values 5 to 8 are used as given, values below 5 act as 5, and values above 8 act as 8. Bits above that count are not sent.
- R3: With `par_en`=1, a parity bit follows the last data bit. With `par_odd`=0 the ones in the sent data bits plus the parity bit are even in number; with `par_odd`=1 they are odd. With `par_en`=0 no parity bit is sent.
- R4: `stop_len`=2 gives two high stop bits; any other value gives one.
- R5: Each bit lasts exactly 16 ticks. A tick is issued when a phase accumulator, advanced by `baud`×16 every clock, passes `CLK_HZ`. When `CLK_HZ` is a multiple of `baud`, a bit therefore lasts `CLK_HZ`/`baud` clocks. The line changes only on a tick.
- R6: With `baud`=0 no ticks occur, so queued bytes wait and the line stays high.
- R7: Bytes leave in the order they were written, including while writes and frame starts happen in the same cycle.
- R8: `wr_full` is high when `DEPTH` bytes are queued. A write while `wr_full` is high is discarded.
- R9: The format inputs are captured at the start of each frame. Changing them during a frame does not alter that frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock at `CLK_HZ` |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe for the queue |
| wr_data | input | 8 | Byte to queue |
| wr_full | output | 1 | Queue holds `DEPTH` bytes |
| baud | input | 17 | Baud rate in bits per second |
| data_len | input | 4 | Number of data bits (5 to 8) |
| stop_len | input | 2 | 2 selects two stop bits, other values one |
| par_en | input | 1 | Send a parity bit |
| par_odd | input | 1 | 0 even parity, 1 odd parity |
| txd | output | 1 | Serial output line |

## Verification
The two functions that can meet in one clock are a producer write into the queue and the transmitter popping the head byte to begin a frame. Either one can also coincide with the queue being full. The bench provokes the first case by writing fourteen bytes on consecutive clocks while frames are already draining, so that one of the writes lands on a frame-start pop. It then decodes the line and requires every byte in write order. The full case is forced by stopping the tick with a zero baud value and overfilling the queue. After the rate is restored, exactly the first sixteen bytes must appear and the line must then stay idle.

// File: rtl/uart_tx_pkg.sv
package uart_tx_pkg;

  localparam int BYTE_W = 8;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_START = 3'd1,
    ST_DATA  = 3'd2,
    ST_PAR   = 3'd3,
    ST_STOP  = 3'd4
  } tx_state_e;

  typedef struct packed {
    logic [2:0] last_idx;
    logic       two_stop;
    logic       par_en;
    logic       par_odd;
  } frame_cfg_t;

  function automatic frame_cfg_t make_cfg(input logic [3:0] dlen, input logic [1:0] slen,
                                          input logic pen, input logic podd);
    frame_cfg_t c;
    logic [3:0] n;
    if (dlen < 4'd5)      n = 4'd5;
    else if (dlen > 4'd8) n = 4'd8;
    else                  n = dlen;
    c.last_idx = 3'(n - 4'd1);
    c.two_stop = (slen == 2'd2);
    c.par_en   = pen;
    c.par_odd  = podd;
    return c;
  endfunction

  function automatic logic [BYTE_W-1:0] bits_mask(input logic [2:0] last);
    logic [BYTE_W-1:0] m;
    for (int i = 0; i < BYTE_W; i++) m[i] = (3'(i) <= last);
    return m;
  endfunction

endpackage

// File: rtl/uart_tx_fifo.sv
module uart_tx_fifo #(
  parameter int DEPTH = 16,
  parameter int W     = 8,
  localparam int AW   = $clog2(DEPTH),
  localparam int LW   = AW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [W-1:0]  wr_data,
  input  logic          rd_en,
  output logic [W-1:0]  rd_data,
  output logic          full,
  output logic          empty,
  output logic [LW-1:0] level
);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wr_ptr_q, wr_ptr_d, rd_ptr_q, rd_ptr_d;
  logic [LW-1:0] cnt_q, cnt_d;
  logic          wr_ok, rd_ok;

  assign full    = (cnt_q == LW'(DEPTH));
  assign empty   = (cnt_q == '0);
  assign level   = cnt_q;
  assign rd_data = mem[rd_ptr_q];
  assign wr_ok   = wr_en & ~full;
  assign rd_ok   = rd_en & ~empty;

  always_comb begin
    wr_ptr_d = wr_ptr_q;
    rd_ptr_d = rd_ptr_q;
    cnt_d    = cnt_q;
    if (wr_ok) wr_ptr_d = wr_ptr_q + AW'(1);
    if (rd_ok) rd_ptr_d = rd_ptr_q + AW'(1);
    case ({wr_ok, rd_ok})
      2'b10:   cnt_d = cnt_q + LW'(1);
      2'b01:   cnt_d = cnt_q - LW'(1);
      default: cnt_d = cnt_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      cnt_q    <= '0;
    end else begin
      wr_ptr_q <= wr_ptr_d;
      rd_ptr_q <= rd_ptr_d;
      cnt_q    <= cnt_d;
    end
  end

  always_ff @(posedge clk) begin
    if (wr_ok) mem[wr_ptr_q] <= wr_data;
  end

endmodule

// File: rtl/uart_tick_gen.sv
module uart_tick_gen #(
  parameter int CLK_HZ = 50_000_000,
  parameter int BAUD_W = 17,
  localparam int INC_W = BAUD_W + 4,
  localparam int CLK_W = $clog2(CLK_HZ + 1),
  localparam int SUM_W = ((INC_W > CLK_W) ? INC_W : CLK_W) + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [BAUD_W-1:0] baud,
  output logic              tick
);

  localparam logic [SUM_W-1:0] CLK_V = SUM_W'(CLK_HZ);

  logic [SUM_W-1:0] acc_q, acc_d, inc, sum;
  logic             tick_q, tick_d;

  assign inc  = SUM_W'({baud, 4'b0000});
  assign sum  = acc_q + inc;
  assign tick = tick_q;

  always_comb begin
    acc_d  = sum;
    tick_d = 1'b0;
    if (inc >= CLK_V) begin
      acc_d  = '0;
      tick_d = 1'b1;
    end else if (sum >= CLK_V) begin
      acc_d  = sum - CLK_V;
      tick_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q  <= '0;
      tick_q <= 1'b0;
    end else begin
      acc_q  <= acc_d;
      tick_q <= tick_d;
    end
  end

endmodule

// File: rtl/uart_tx_engine.sv
module uart_tx_engine
  import uart_tx_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              empty,
  input  logic [BYTE_W-1:0] head,
  input  frame_cfg_t        cfg_in,
  output logic              pop,
  output logic              busy,
  output logic              txd
);

  tx_state_e         st_q, st_d;
  logic [3:0]        cnt_q, cnt_d;
  logic [2:0]        idx_q, idx_d;
  logic [BYTE_W-1:0] sh_q, sh_d;
  logic              par_q, par_d, stop2_q, stop2_d, load;
  frame_cfg_t        cfg_q, cfg_d;

  always_comb begin
    st_d    = st_q;
    cnt_d   = cnt_q;
    idx_d   = idx_q;
    sh_d    = sh_q;
    par_d   = par_q;
    cfg_d   = cfg_q;
    stop2_d = stop2_q;
    load    = 1'b0;
    if (tick) begin
      if (st_q == ST_IDLE) begin
        load = ~empty;
      end else begin
        cnt_d = cnt_q + 4'd1;
        if (cnt_q == 4'hF) begin
          case (st_q)
            ST_START: begin
              st_d  = ST_DATA;
              idx_d = '0;
            end
            ST_DATA: begin
              sh_d  = sh_q >> 1;
              idx_d = idx_q + 3'd1;
              if (idx_q == cfg_q.last_idx) begin
                st_d    = cfg_q.par_en ? ST_PAR : ST_STOP;
                stop2_d = 1'b0;
              end
            end
            ST_PAR: begin
              st_d    = ST_STOP;
              stop2_d = 1'b0;
            end
            ST_STOP: begin
              if (cfg_q.two_stop && !stop2_q) stop2_d = 1'b1;
              else if (!empty)                load    = 1'b1;
              else                            st_d    = ST_IDLE;
            end
            default: st_d = ST_IDLE;
          endcase
        end
      end
    end
    if (load) begin
      st_d  = ST_START;
      cnt_d = '0;
      sh_d  = head;
      cfg_d = cfg_in;
      par_d = (^(head & bits_mask(cfg_in.last_idx))) ^ cfg_in.par_odd;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= ST_IDLE;
      cnt_q   <= '0;
      idx_q   <= '0;
      sh_q    <= '0;
      par_q   <= 1'b0;
      stop2_q <= 1'b0;
      cfg_q   <= '0;
    end else begin
      st_q    <= st_d;
      cnt_q   <= cnt_d;
      idx_q   <= idx_d;
      sh_q    <= sh_d;
      par_q   <= par_d;
      stop2_q <= stop2_d;
      cfg_q   <= cfg_d;
    end
  end

  assign pop  = load;
  assign busy = (st_q != ST_IDLE);

  always_comb begin
    case (st_q)
      ST_START: txd = 1'b0;
      ST_DATA:  txd = sh_q[0];
      ST_PAR:   txd = par_q;
      default:  txd = 1'b1;
    endcase
  end

endmodule

// File: rtl/uart_fifo_tx.sv
module uart_fifo_tx
  import uart_tx_pkg::*;
#(
  parameter int CLK_HZ = 50_000_000,
  parameter int DEPTH  = 16,
  parameter int BAUD_W = 17,
  localparam int LW    = $clog2(DEPTH) + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [7:0]        wr_data,
  output logic              wr_full,
  input  logic [BAUD_W-1:0] baud,
  input  logic [3:0]        data_len,
  input  logic [1:0]        stop_len,
  input  logic              par_en,
  input  logic              par_odd,
  output logic              txd
);

  logic              rst_meta, rst_n_i;
  logic              baud_tick, fifo_pop, fifo_empty, tx_busy;
  logic [BYTE_W-1:0] fifo_head;
  logic [LW-1:0]     fifo_level;
  frame_cfg_t        cfg_now;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta <= 1'b0;
      rst_n_i  <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      rst_n_i  <= rst_meta;
    end
  end

  assign cfg_now = make_cfg(data_len, stop_len, par_en, par_odd);

  uart_tx_fifo #(.DEPTH(DEPTH), .W(BYTE_W)) u_fifo (
    .clk     (clk),
    .rst_n   (rst_n_i),
    .wr_en   (wr_en),
    .wr_data (wr_data),
    .rd_en   (fifo_pop),
    .rd_data (fifo_head),
    .full    (wr_full),
    .empty   (fifo_empty),
    .level   (fifo_level)
  );

  uart_tick_gen #(.CLK_HZ(CLK_HZ), .BAUD_W(BAUD_W)) u_tick (
    .clk   (clk),
    .rst_n (rst_n_i),
    .baud  (baud),
    .tick  (baud_tick)
  );

  uart_tx_engine u_eng (
    .clk    (clk),
    .rst_n  (rst_n_i),
    .tick   (baud_tick),
    .empty  (fifo_empty),
    .head   (fifo_head),
    .cfg_in (cfg_now),
    .pop    (fifo_pop),
    .busy   (tx_busy),
    .txd    (txd)
  );

endmodule

// File: rtl/uart_fifo_tx_chk.sv
module uart_fifo_tx_chk #(
  parameter int DEPTH  = 16,
  parameter int BAUD_W = 17,
  parameter int LW     = 5
) (
  input logic              clk,
  input logic              rst_n,
  input logic              txd,
  input logic              busy,
  input logic              tick,
  input logic              pop,
  input logic              wr_en,
  input logic              full,
  input logic [LW-1:0]     level,
  input logic [BAUD_W-1:0] baud
);

  p_idle_line_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> txd);

  p_bit_edge_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(txd));

  p_halt_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (baud == '0 && $past(baud) == '0) |-> !tick);

  p_pop_gate_r7: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> (tick && level != '0));

  p_no_overflow_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (full && wr_en && !pop) |=> $stable(level));

  p_level_cap_r8: assert property (@(posedge clk) disable iff (!rst_n)
    level <= LW'(DEPTH));

endmodule

bind uart_fifo_tx uart_fifo_tx_chk #(.DEPTH(DEPTH), .BAUD_W(BAUD_W), .LW(LW)) u_chk (
  .clk   (clk),
  .rst_n (rst_n),
  .txd   (txd),
  .busy  (tx_busy),
  .tick  (baud_tick),
  .pop   (fifo_pop),
  .wr_en (wr_en),
  .full  (wr_full),
  .level (fifo_level),
  .baud  (baud)
);

// File: tb/uart_fifo_tx_bench.sv
module uart_fifo_tx_bench;

  localparam int CLK_PERIOD = 10;
  localparam int CLK_HZ     = 1_843_200;
  localparam int DEPTH      = 16;

  logic        clk, rst_n, wr_en, wr_full, par_en, par_odd, txd;
  logic [7:0]  wr_data;
  logic [16:0] baud;
  logic [3:0]  data_len;
  logic [1:0]  stop_len;
  int          nvec, nfail;

  uart_fifo_tx #(.CLK_HZ(CLK_HZ), .DEPTH(DEPTH)) u_uart_fifo_tx (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .wr_full(wr_full),
    .baud(baud), .data_len(data_len), .stop_len(stop_len), .par_en(par_en),
    .par_odd(par_odd), .txd(txd)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nvec++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic set_cfg(input int dl, input int sl, input bit pe, input bit po);
    @(negedge clk);
    data_len = 4'(dl); stop_len = 2'(sl); par_en = pe; par_odd = po;
  endtask

  task automatic push(input logic [7:0] b);
    @(negedge clk);
    wr_en = 1'b1; wr_data = b;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic wait_fall(output bit ok);
    int t = 0;
    while (txd !== 1'b0 && t < 20000) begin
      @(negedge clk);
      t++;
    end
    ok = (txd === 1'b0);
  endtask

  // expects the frame format given; data count is the effective 5..8
  task automatic recv(input logic [7:0] exp, input int nbits, input bit two, input bit pe,
                      input bit po, input int bitclk, input string req);
    bit ok;
    logic [7:0] got, mask;
    got = '0;
    mask = 8'((1 << nbits) - 1);
    wait_fall(ok);
    chk(ok, {req, " start edge"}, 0, 1);
    if (ok) begin
      repeat (bitclk/2 - 1) @(negedge clk);
      chk(txd === 1'b0, "R2 start bit", int'(txd), 0);
      for (int i = 0; i < nbits; i++) begin
        repeat (bitclk) @(negedge clk);
        got[i] = txd;
      end
      chk(got == (exp & mask), req, int'(got), int'(exp & mask));
      if (pe) begin
        repeat (bitclk) @(negedge clk);
        chk(txd === ((^(exp & mask)) ^ po), "R3 parity", int'(txd), int'((^(exp & mask)) ^ po));
      end
      for (int s = 0; s < (two ? 2 : 1); s++) begin
        repeat (bitclk) @(negedge clk);
        chk(txd === 1'b1, "R4 stop bit", int'(txd), 1);
      end
    end
  endtask

  task automatic low_run(input int exp, input string req);
    bit ok;
    int n = 0;
    wait_fall(ok);
    while (txd === 1'b0 && n < 1000) begin
      n++;
      @(negedge clk);
    end
    chk(ok && n == exp, req, n, exp);
    repeat (12 * exp) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
    $finish;
  end

  initial begin
    bit idle_ok;
    nvec = 0; nfail = 0;
    rst_n = 1'b0; wr_en = 1'b0; wr_data = '0; baud = 17'd115200;
    data_len = 4'd8; stop_len = 2'd1; par_en = 1'b1; par_odd = 1'b0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    chk(txd === 1'b1, "R1 idle line", int'(txd), 1);
    chk(wr_full === 1'b0, "R1 full low", int'(wr_full), 0);

    // format sweep R2 R3 R4
    for (int dl = 5; dl <= 8; dl++)
      for (int sl = 1; sl <= 2; sl++)
        for (int pe = 0; pe < 2; pe++)
          for (int po = 0; po < 2; po++) begin
            logic [7:0] b0;
            b0 = 8'(dl * 29 + sl * 7 + pe * 3 + po * 11 + 8'h5A);
            set_cfg(dl, sl, pe[0], po[0]);
            push(b0);
            push(~b0);
            recv(b0, dl, sl == 2, pe[0], po[0], 16, "R2 data");
            recv(~b0, dl, sl == 2, pe[0], po[0], 16, "R2 data");
          end

    // length clamping R2
    set_cfg(12, 1, 1'b1, 1'b1);
    push(8'h96);
    recv(8'h96, 8, 1'b0, 1'b1, 1'b1, 16, "R2 clamp high");
    set_cfg(2, 1, 1'b0, 1'b0);
    push(8'h6B);
    recv(8'h6B, 5, 1'b0, 1'b0, 1'b0, 16, "R2 clamp low");

    // writes racing frame starts R7
    set_cfg(8, 1, 1'b1, 1'b0);
    fork
      begin
        for (int i = 0; i < 14; i++) begin
          @(negedge clk);
          wr_en = 1'b1; wr_data = 8'(i + 1);
        end
        @(negedge clk);
        wr_en = 1'b0;
      end
      begin
        for (int i = 0; i < 14; i++) recv(8'(i + 1), 8, 1'b0, 1'b1, 1'b0, 16, "R7 order");
      end
    join

    // halt and overfill R6 R8
    baud = 17'd0;
    repeat (4) @(negedge clk);
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      wr_en = 1'b1; wr_data = 8'(8'h30 + i);
    end
    @(negedge clk);
    wr_en = 1'b0;
    chk(wr_full === 1'b1, "R8 full flag", int'(wr_full), 1);
    idle_ok = 1'b1;
    for (int i = 0; i < 100; i++) begin
      @(negedge clk);
      if (txd !== 1'b1) idle_ok = 1'b0;
    end
    chk(idle_ok, "R6 no frame at zero baud", int'(idle_ok), 1);
    baud = 17'd115200;
    for (int i = 0; i < 16; i++) recv(8'(8'h30 + i), 8, 1'b0, 1'b1, 1'b0, 16, "R8 kept bytes");
    idle_ok = 1'b1;
    for (int i = 0; i < 600; i++) begin
      @(negedge clk);
      if (txd !== 1'b1) idle_ok = 1'b0;
    end
    chk(idle_ok, "R8 dropped writes absent", int'(idle_ok), 1);
    chk(wr_full === 1'b0, "R8 full cleared", int'(wr_full), 0);

    // mid-frame format change R9
    set_cfg(8, 1, 1'b1, 1'b0);
    push(8'hC3);
    fork
      recv(8'hC3, 8, 1'b0, 1'b1, 1'b0, 16, "R9 frame kept old format");
      begin
        repeat (40) @(negedge clk);
        data_len = 4'd5; stop_len = 2'd2; par_en = 1'b0; par_odd = 1'b1;
      end
    join
    push(8'h3C);
    recv(8'h3C, 5, 1'b1, 1'b0, 1'b1, 16, "R9 next frame new format");

    // bit timing R5
    set_cfg(8, 1, 1'b1, 1'b0);
    repeat (40) @(negedge clk);
    push(8'h01);
    low_run(16, "R5 start length 115200");
    baud = 17'd57600;
    repeat (4) @(negedge clk);
    push(8'h01);
    low_run(32, "R5 start length 57600");
    push(8'hE7);
    recv(8'hE7, 8, 1'b0, 1'b1, 1'b0, 32, "R5 data at 57600");

    repeat (50) @(negedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
    $finish;
  end

endmodule